// File: doc/BRIEF.md
# Write-Update Write-Back Snoop Controller

This block is the coherence controller of one small direct-mapped cache on a shared snooping bus. Each cache line holds a single word and is in one of five states: invalid, valid exclusive, shared clean, shared dirty or dirty. Writes to a shared line are broadcast to the other caches, which take the new word. Memory is never written by those broadcasts. It is written only when a line that owns its block (dirty or shared dirty) is evicted. The shared dirty state gives ownership of a block to exactly one of several sharers, so a block has one writer-back at most.

The processor side is a simple request/response port. The request is held until a one-cycle response pulse. On the bus side the controller raises a request, waits for a grant and then runs one command per granted cycle: a writeback of a victim, a read, or an update broadcast. Grants come from outside. Every cache also snoops the bus. It drives a wired-OR shared line when it holds the addressed block, and on a read it supplies its copy. The system fills a read from that supplied word when the shared line is high, and from memory otherwise.

Top module: `upd_wb_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, and `resp_valid` and `bus_req` are low.
- R2: A read hit returns the stored word in the response. It uses no bus cycle and leaves the line state unchanged.
- R3: A read miss issues a read command (`bus_cmd` 1). If the shared line is low, the fill comes from memory and the line becomes valid exclusive. If it is high, the fill comes from a holder and the line becomes shared clean. A snooping holder drives the shared line and its word on a read or an update to its block.
- R4: A snooped read moves a valid exclusive or shared clean holder to shared clean. It moves a dirty or shared dirty holder to shared dirty, so the holder keeps ownership and still writes the block back on eviction.
- R5: A write hit on a valid exclusive or dirty line writes the word locally, sets dirty and uses no bus cycle.
- R6: A write hit on a shared clean or shared dirty line broadcasts an update command (`bus_cmd` 2) carrying the new word. The writer becomes shared dirty if the shared line is high during the broadcast, and dirty if it is low. Snooping holders take the word and become shared clean.
- R7: A write miss first issues a read. If no other cache holds the block, the writer becomes dirty with no broadcast. Otherwise it follows the read with an update broadcast and becomes shared dirty, and the other holders become shared clean.
- R8: Before the fill read, a miss that evicts a dirty or shared dirty line issues a writeback command (`bus_cmd` 3) with the victim's address and word. A valid exclusive or shared clean victim is dropped silently. Memory takes data only from writeback commands.
- R9: At most one cache owns a block at any time. After every cache has evicted every line, each block has been written back at most once in that flush, and memory holds the last value written to every address.
- R10: A processor request is not acted on in a cycle in which the cache is being snooped. It is served afterwards. Two caches that write a shared block in the same cycle are ordered by the bus grant, and the word of the later granted writer is the one every cache and memory end with.

Addresses are `{tag, index}`, with the index in the low `IW` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request, held until `resp_valid` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write word |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DW | Read result |
| bus_req | output | 1 | Bus wanted; stays high across chained commands |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_valid | output | 1 | A command is on the bus this cycle |
| bus_cmd | output | 2 | 1 read, 2 update, 3 writeback |
| bus_addr | output | AW | Command address |
| bus_wdata | output | DW | Update or writeback word |
| bus_rdata | input | DW | Fill word (holder copy or memory) |
| bus_shared_in | input | 1 | Wired-OR shared line from the other caches |
| snp_valid | input | 1 | Another cache's command is being snooped |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | AW | Snooped address |
| snp_wdata | input | DW | Snooped update word |
| snp_shared_out | output | 1 | This cache holds the snooped block |
| snp_supply_data | output | DW | This cache's copy of the snooped block |

## Verification
Two things can land on a cache in the same cycle: a snoop from another cache's bus command, and a new request from its own processor. Sometimes both touch the same block. The bench provokes this by presenting a read two cycles after another cache starts a write miss, so the read lands while the bus is busy. It judges the read by the returned word. The bench also has two caches holding the same block write it in the same cycle. It judges that race by the word every cache returns afterwards and by the word that reaches memory in the final flush, against the grant order.

// File: rtl/upd_wb_snoop_ctrl.sv
module upd_wb_snoop_ctrl #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_valid,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_shared_in,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_wdata,
  output logic          snp_shared_out,
  output logic [DW-1:0] snp_supply_data
);
  localparam int NL = 1 << IW;
  localparam int TW = AW - IW;

  localparam logic [2:0] L_I = 3'd0, L_VE = 3'd1, L_SC = 3'd2, L_SD = 3'd3, L_D = 3'd4;
  localparam logic [1:0] C_RD = 2'd1, C_UPD = 2'd2, C_WB = 2'd3;
  localparam logic [2:0] F_IDLE = 3'd0, F_WB = 3'd1, F_RD = 3'd2, F_UPD = 3'd3, F_RESP = 3'd4;

  logic [2:0]    lst  [NL];
  logic [TW-1:0] ltag [NL];
  logic [DW-1:0] ldat [NL];
  logic [2:0]    fst;
  logic [DW-1:0] rdat_q;

  logic [IW-1:0] ridx, sidx;
  logic [TW-1:0] rtag, stag;
  logic          r_hit, v_own, s_hit, s_own;

  assign ridx  = req_addr[IW-1:0];
  assign rtag  = req_addr[AW-1:IW];
  assign sidx  = snp_addr[IW-1:0];
  assign stag  = snp_addr[AW-1:IW];
  assign r_hit = (lst[ridx] != L_I) && (ltag[ridx] == rtag);
  assign v_own = (lst[ridx] == L_SD) || (lst[ridx] == L_D);
  assign s_own = (lst[sidx] == L_SD) || (lst[sidx] == L_D);
  assign s_hit = snp_valid && (snp_cmd != C_WB) && (lst[sidx] != L_I) && (ltag[sidx] == stag);

  assign snp_shared_out  = s_hit;
  assign snp_supply_data = ldat[sidx];

  assign bus_req   = (fst == F_WB) || (fst == F_RD) || (fst == F_UPD);
  assign bus_valid = bus_gnt && ((fst == F_RD) || (fst == F_UPD) || (fst == F_WB && v_own));
  assign bus_cmd   = (fst == F_WB) ? C_WB : (fst == F_RD) ? C_RD : C_UPD;
  assign bus_addr  = (fst == F_WB) ? {ltag[ridx], ridx} : req_addr;
  assign bus_wdata = (fst == F_WB) ? ldat[ridx] : req_wdata;

  assign resp_valid = (fst == F_RESP);
  assign resp_rdata = rdat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fst    <= F_IDLE;
      rdat_q <= '0;
      for (int i = 0; i < NL; i++) begin
        lst[i]  <= L_I;
        ltag[i] <= '0;
        ldat[i] <= '0;
      end
    end else begin
      if (s_hit) begin
        if (snp_cmd == C_RD) begin
          lst[sidx] <= s_own ? L_SD : L_SC;
        end else begin
          ldat[sidx] <= snp_wdata;
          lst[sidx]  <= L_SC;
        end
      end
      case (fst)
        F_IDLE: if (req_valid && !snp_valid) begin
          if (r_hit && !req_we) begin
            rdat_q <= ldat[ridx];
            fst    <= F_RESP;
          end else if (r_hit && (lst[ridx] == L_VE || lst[ridx] == L_D)) begin
            ldat[ridx] <= req_wdata;
            lst[ridx]  <= L_D;
            fst        <= F_RESP;
          end else if (r_hit) begin
            fst <= F_UPD;
          end else begin
            fst <= v_own ? F_WB : F_RD;
          end
        end
        F_WB: if (bus_gnt) begin
          lst[ridx] <= L_I;
          fst       <= F_RD;
        end
        F_RD: if (bus_gnt) begin
          ltag[ridx] <= rtag;
          if (!req_we) begin
            ldat[ridx] <= bus_rdata;
            lst[ridx]  <= bus_shared_in ? L_SC : L_VE;
            rdat_q     <= bus_rdata;
            fst        <= F_RESP;
          end else if (bus_shared_in) begin
            lst[ridx] <= L_SC;
            fst       <= F_UPD;
          end else begin
            ldat[ridx] <= req_wdata;
            lst[ridx]  <= L_D;
            fst        <= F_RESP;
          end
        end
        F_UPD: if (bus_gnt) begin
          ldat[ridx] <= req_wdata;
          lst[ridx]  <= bus_shared_in ? L_SD : L_D;
          fst        <= F_RESP;
        end
        default: fst <= F_IDLE;
      endcase
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) $fell(rst_n) |=> !resp_valid && !bus_req);

  a_r2_read_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
    fst == F_IDLE && req_valid && !snp_valid && !req_we && r_hit
    |=> resp_valid && !bus_req && resp_rdata == $past(ldat[ridx]));

  a_r4_owner_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    s_hit && snp_cmd == C_RD && s_own |=> lst[$past(sidx)] == L_SD);

  a_r5_silent_write: assert property (@(posedge clk) disable iff (!rst_n)
    fst == F_IDLE && req_valid && !snp_valid && req_we && r_hit && (lst[ridx] == L_VE || lst[ridx] == L_D)
    |=> resp_valid && !bus_req && lst[$past(ridx)] == L_D);

  a_r6_snooped_update: assert property (@(posedge clk) disable iff (!rst_n)
    s_hit && snp_cmd == C_UPD |=> lst[$past(sidx)] == L_SC && ldat[$past(sidx)] == $past(snp_wdata));

  a_r6_writer_owner: assert property (@(posedge clk) disable iff (!rst_n)
    fst == F_UPD && bus_gnt |=> resp_valid && lst[$past(ridx)] == ($past(bus_shared_in) ? L_SD : L_D));

  a_r7_private_write_miss: assert property (@(posedge clk) disable iff (!rst_n)
    fst == F_RD && bus_gnt && req_we && !bus_shared_in |=> resp_valid && lst[$past(ridx)] == L_D);

  a_r8_wb_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_cmd == C_WB |=> fst == F_RD && bus_req);

  a_r10_snoop_defers: assert property (@(posedge clk) disable iff (!rst_n)
    fst == F_IDLE && snp_valid |=> !resp_valid);
endmodule

// File: tb/upd_wb_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module upd_wb_snoop_ctrl_tb_top;
  localparam int NC = 3, AW = 4, DW = 8, IW = 1, NL = 2, NA = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NC-1:0] req_valid, req_we, resp_valid, bus_req, bus_gnt, bus_valid, snp_valid, shr;
  logic [AW-1:0] req_addr [NC];
  logic [AW-1:0] bus_addr [NC];
  logic [DW-1:0] req_wdata [NC];
  logic [DW-1:0] resp_rdata [NC];
  logic [DW-1:0] bus_wdata [NC];
  logic [DW-1:0] sup_data [NC];
  logic [1:0]    bus_cmd [NC];

  logic          busy;
  logic [1:0]    own, pick;
  logic          m_valid, shared_any;
  logic [1:0]    m_cmd;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data, sup_or, fill;
  logic [DW-1:0] mem [NA];

  int checks = 0, fails = 0;
  int mst [NC][NL];
  logic [2:0] mtag [NC][NL];
  logic [DW-1:0] mdat [NC][NL];
  logic [DW-1:0] gval [NA];
  int wbcnt [NA];

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a * 29 + 7);
  endfunction

  always_comb begin
    m_valid = busy && bus_valid[own];
    m_cmd   = bus_cmd[own];
    m_addr  = bus_addr[own];
    m_data  = bus_wdata[own];
    shared_any = |shr;
    sup_or = '0;
    pick = 2'd0;
    for (int i = NC - 1; i >= 0; i--) if (bus_req[i]) pick = 2'(i);
    for (int i = 0; i < NC; i++) begin
      if (shr[i]) sup_or = sup_or | sup_data[i];
      snp_valid[i] = m_valid && (own != 2'(i));
      bus_gnt[i]   = busy && (own == 2'(i));
    end
    fill = shared_any ? sup_or : mem[m_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      own  <= 2'd0;
      for (int a = 0; a < NA; a++) mem[a] <= init_val(a);
    end else begin
      if (m_valid && m_cmd == 2'd3) mem[m_addr] <= m_data;
      if (busy) begin
        if (!bus_req[own]) busy <= 1'b0;
      end else if (|bus_req) begin
        busy <= 1'b1;
        own  <= pick;
      end
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_c
    upd_wb_snoop_ctrl #(.AW(AW), .DW(DW), .IW(IW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid[i]), .req_we(req_we[i]), .req_addr(req_addr[i]), .req_wdata(req_wdata[i]),
      .resp_valid(resp_valid[i]), .resp_rdata(resp_rdata[i]),
      .bus_req(bus_req[i]), .bus_gnt(bus_gnt[i]), .bus_valid(bus_valid[i]), .bus_cmd(bus_cmd[i]),
      .bus_addr(bus_addr[i]), .bus_wdata(bus_wdata[i]), .bus_rdata(fill), .bus_shared_in(shared_any),
      .snp_valid(snp_valid[i]), .snp_cmd(m_cmd), .snp_addr(m_addr), .snp_wdata(m_data),
      .snp_shared_out(shr[i]), .snp_supply_data(sup_data[i]));
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_op(input int c, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit chk, output logic [DW-1:0] rd);
    int idx = int'(a[0]);
    logic [2:0] tg = a[3:1];
    bit hit, sh, e_wb, e_upd;
    logic [AW-1:0] e_wba;
    logic [DW-1:0] e_wbd, e_rdata;
    int n_wb = 0, n_rd = 0, n_upd = 0, t = 0;
    logic [AW-1:0] g_wba = '0;
    logic [DW-1:0] g_wbd = '0, g_upd = '0;
    string lr;
    hit = mst[c][idx] != 0 && mtag[c][idx] == tg;
    sh = 1'b0;
    for (int o = 0; o < NC; o++)
      if (o != c && mst[o][idx] != 0 && mtag[o][idx] == tg) sh = 1'b1;
    e_wb    = !hit && (mst[c][idx] == 3 || mst[c][idx] == 4);
    e_wba   = {mtag[c][idx], a[0]};
    e_wbd   = mdat[c][idx];
    e_upd   = we && ((hit && (mst[c][idx] == 2 || mst[c][idx] == 3)) || (!hit && sh));
    e_rdata = hit ? mdat[c][idx] : gval[a];

    req_we[c] = we; req_addr[c] = a; req_wdata[c] = d; req_valid[c] = 1'b1;
    forever begin
      @(negedge clk);
      t++;
      if (busy && own == 2'(c) && bus_valid[c]) begin
        if (bus_cmd[c] == 2'd3) begin n_wb++; g_wba = bus_addr[c]; g_wbd = bus_wdata[c]; wbcnt[bus_addr[c]]++; end
        if (bus_cmd[c] == 2'd1) n_rd++;
        if (bus_cmd[c] == 2'd2) begin n_upd++; g_upd = bus_wdata[c]; end
      end
      if (resp_valid[c]) break;
      if (t > 80) begin
        check(1'b0, "R10", "request never completed", t, 80);
        break;
      end
    end
    rd = resp_rdata[c];
    req_valid[c] = 1'b0;

    if (chk) begin
      if (!we) check(rd == e_rdata, hit ? "R2" : "R3", "read data", rd, e_rdata);
      check(n_wb == int'(e_wb), "R8", "writeback count (R4 ownership)", n_wb, int'(e_wb));
      if (e_wb) begin
        check(g_wba == e_wba, "R8", "writeback address", g_wba, e_wba);
        check(g_wbd == e_wbd, "R8", "writeback data", g_wbd, e_wbd);
      end
      check(n_rd == int'(!hit), we ? "R7" : (hit ? "R2" : "R3"), "read command count", n_rd, int'(!hit));
      lr = !we ? "R2" : (!hit ? "R7" : (e_upd ? "R6" : "R5"));
      check(n_upd == int'(e_upd), lr, "update command count", n_upd, int'(e_upd));
      if (e_upd) check(g_upd == d, lr, "update data", g_upd, d);

      if (!hit) begin
        for (int o = 0; o < NC; o++)
          if (o != c && mst[o][idx] != 0 && mtag[o][idx] == tg)
            mst[o][idx] = (mst[o][idx] >= 3) ? 3 : 2;
        mtag[c][idx] = tg;
        if (!we) begin
          mst[c][idx] = sh ? 2 : 1;
          mdat[c][idx] = gval[a];
        end else begin
          mst[c][idx] = sh ? 3 : 4;
          mdat[c][idx] = d;
        end
      end else if (we) begin
        if (mst[c][idx] == 1 || mst[c][idx] == 4) mst[c][idx] = 4;
        else mst[c][idx] = sh ? 3 : 4;
        mdat[c][idx] = d;
      end
      if (we && e_upd)
        for (int o = 0; o < NC; o++)
          if (o != c && mst[o][idx] != 0 && mtag[o][idx] == tg) begin
            mst[o][idx] = 2;
            mdat[o][idx] = d;
          end
    end
    if (we) gval[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 150000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    logic [DW-1:0] rd, rd1;
    logic [AW-1:0] aa;
    req_valid = '0; req_we = '0;
    for (int i = 0; i < NC; i++) begin req_addr[i] = '0; req_wdata[i] = '0; end
    for (int a = 0; a < NA; a++) begin gval[a] = init_val(a); wbcnt[a] = 0; end
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NL; i++) begin mst[c][i] = 0; mtag[c][i] = '0; mdat[c][i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      check(!resp_valid[c], "R1", "resp_valid after reset", resp_valid[c], 0);
      check(!bus_req[c], "R1", "bus_req after reset", bus_req[c], 0);
    end
    do_op(0, 1'b0, 4'd2, 8'd0, 1'b1, rd);
    check(rd == init_val(2), "R1", "first access fills from memory", rd, init_val(2));

    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_op(int'(lf[1:0]) % NC, lf[4], {1'b0, lf[7:6], lf[8]}, lf[15:8] ^ 8'(n), 1'b1, rd);
    end

    do_op(0, 1'b0, 4'd5, 8'd0, 1'b1, rd);
    do_op(1, 1'b0, 4'd5, 8'd0, 1'b1, rd);
    fork
      do_op(0, 1'b1, 4'd5, 8'h3C, 1'b0, rd);
      do_op(1, 1'b1, 4'd5, 8'hC3, 1'b0, rd1);
    join
    gval[5] = 8'hC3;
    do_op(2, 1'b0, 4'd5, 8'd0, 1'b0, rd);
    check(rd == 8'hC3, "R10", "racing writes, third cache", rd, 8'hC3);
    do_op(0, 1'b0, 4'd5, 8'd0, 1'b0, rd);
    check(rd == 8'hC3, "R10", "racing writes, first writer", rd, 8'hC3);

    do_op(1, 1'b0, 4'd3, 8'd0, 1'b0, rd);
    fork
      do_op(0, 1'b1, 4'd2, 8'h77, 1'b0, rd);
      begin
        repeat (2) @(negedge clk);
        do_op(1, 1'b0, 4'd3, 8'd0, 1'b0, rd1);
      end
    join
    check(rd1 == gval[3], "R10", "read during snoop", rd1, gval[3]);
    do_op(2, 1'b0, 4'd2, 8'd0, 1'b0, rd);
    check(rd == 8'h77, "R10", "write miss after deferred read", rd, 8'h77);

    for (int a = 0; a < NA; a++) wbcnt[a] = 0;
    for (int c = 0; c < NC; c++)
      for (int t = 6; t < 8; t++)
        for (int i = 0; i < NL; i++) begin
          aa = {3'(t), 1'(i)};
          do_op(c, 1'b0, aa, 8'd0, 1'b0, rd);
          check(rd == gval[aa], "R3", "flush read data", rd, gval[aa]);
        end
    repeat (2) @(negedge clk);
    for (int a = 0; a < NA; a++) begin
      check(wbcnt[a] <= 1, "R9", "writebacks per block in flush", wbcnt[a], 1);
      check(mem[a] == gval[a], "R9", "memory after flush", mem[a], gval[a]);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule